// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block gathers interrupt requests from a DMA engine with up to eight transmit channels and up to eight receive channels, plus a single host-error source. Each source drives a level. The block samples that level into a raw status bit and then gates it with a per-source enable held in a mask. Software never writes the mask directly. It turns enables on through a set address and off through a clear address, so a driver can change one channel's enable without a read-modify-write.

The three groups are transmit, receive and DMA-error. For each group, software can read the raw status and the masked status. It can also read back the current mask from either the set address or the clear address. All masked bits are combined into one registered interrupt line. A vector register reports the highest-priority pending source. Software acknowledges an interrupt by writing to an end-of-interrupt address. That write drops the line for one cycle, so a downstream edge-sensitive controller sees a fresh edge if anything is still pending.

Top module: `irq_mask_ctrl`

## Requirements
- R1: Out of reset, every mask bit is 0, every raw status bit is 0 and `irq_o` is low.
- R2: Raw status reads at 0x80 (transmit), 0xA0 (receive) and 0xB0 (DMA). Channel n maps to bit n of its group. The host error maps to bit 1 of the DMA group. Each bit equals the source level sampled at the previous clock edge.
- R3: A write to 0x88, 0xA8 or 0xB8 sets the mask bits where the write data holds a 1. Bits where the data holds a 0 are left unchanged.
- R4: A write to 0x8C, 0xAC or 0xBC clears the mask bits where the write data holds a 1. Writing 0xFFFFFFFF disables the whole group in one write.
- R5: Reading either the set address or the clear address of a group returns that group's mask. Bits at or above NUM_CH read 0. Every DMA bit other than bit 1 reads 0.
- R6: Masked status at 0x84, 0xA4 and 0xB4 reads as raw status ANDed with the mask.
- R7: Register writes, including writes to the raw and masked addresses, never change raw status.
- R8: In each cycle, `irq_o` is high exactly when some masked status bit was set in the previous cycle, unless R9 applies.
- R9: Any write to 0x94 (end of interrupt; the data is ignored) forces `irq_o` low in the next cycle. After that cycle, `irq_o` follows R8 again.
- R10: The vector register at 0x90 has the following fields:
  - Bit 31 is 1 when any masked bit is set.
  - Bits [9:8] give the group: 2 for DMA, 1 for receive, 0 for transmit.
  - The low bits give the channel.

  Priority runs from host error, to the lowest receive channel, to the lowest transmit channel. When nothing is pending, the register reads 0.
- R11: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address |
| tx_evt_i | input | NUM_CH | Transmit channel interrupt levels |
| rx_evt_i | input | NUM_CH | Receive channel interrupt levels |
| host_err_i | input | 1 | DMA host-error level |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with NUM_CH = 6, fewer than the eight bit slots per group. An all-ones set write therefore shows that the two unimplemented enables stay at zero. With six channels the vector's channel field still needs three bits, so the group and priority fields are exercised in a layout that is not a power of two. The bench also compares the interrupt line every cycle against a behavioural model, which exposes the one-cycle drop after an end-of-interrupt write.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam logic [7:0] OFS_TX_RAW  = 8'h80;
  localparam logic [7:0] OFS_TX_MSK  = 8'h84;
  localparam logic [7:0] OFS_TX_SET  = 8'h88;
  localparam logic [7:0] OFS_TX_CLR  = 8'h8C;
  localparam logic [7:0] OFS_VECTOR  = 8'h90;
  localparam logic [7:0] OFS_EOI     = 8'h94;
  localparam logic [7:0] OFS_RX_RAW  = 8'hA0;
  localparam logic [7:0] OFS_RX_MSK  = 8'hA4;
  localparam logic [7:0] OFS_RX_SET  = 8'hA8;
  localparam logic [7:0] OFS_RX_CLR  = 8'hAC;
  localparam logic [7:0] OFS_DMA_RAW = 8'hB0;
  localparam logic [7:0] OFS_DMA_MSK = 8'hB4;
  localparam logic [7:0] OFS_DMA_SET = 8'hB8;
  localparam logic [7:0] OFS_DMA_CLR = 8'hBC;

  localparam int HOST_ERR_BIT = 1;
  localparam int VEC_VALID_BIT = 31;
  localparam int VEC_GRP_LSB = 8;

  typedef enum logic [1:0] {
    GRP_TX  = 2'd0,
    GRP_RX  = 2'd1,
    GRP_DMA = 2'd2
  } irq_grp_e;
endpackage

// File: rtl/irq_src_grp.sv
module irq_src_grp #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] raw_q, mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (set_i) mask_d = mask_d | bits_i;
    if (clr_i) mask_d = mask_d & ~bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= src_i;
      mask_q <= mask_d;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign pend_o = raw_q & mask_q;
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc
  import irq_mask_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] tx_pend_i,
  input  logic [NUM_CH-1:0] rx_pend_i,
  input  logic              dma_pend_i,
  output logic [31:0]       vec_o
);
  logic [CH_W-1:0] tx_idx, rx_idx;

  // scan downward so the lowest pending index wins
  always_comb begin
    tx_idx = '0;
    rx_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (tx_pend_i[i]) tx_idx = CH_W'(i);
      if (rx_pend_i[i]) rx_idx = CH_W'(i);
    end
  end

  always_comb begin
    vec_o = '0;
    if (dma_pend_i) begin
      vec_o[VEC_VALID_BIT] = 1'b1;
      vec_o[VEC_GRP_LSB +: 2] = GRP_DMA;
      vec_o[CH_W-1:0] = CH_W'(HOST_ERR_BIT);
    end else if (|rx_pend_i) begin
      vec_o[VEC_VALID_BIT] = 1'b1;
      vec_o[VEC_GRP_LSB +: 2] = GRP_RX;
      vec_o[CH_W-1:0] = rx_idx;
    end else if (|tx_pend_i) begin
      vec_o[VEC_VALID_BIT] = 1'b1;
      vec_o[VEC_GRP_LSB +: 2] = GRP_TX;
      vec_o[CH_W-1:0] = tx_idx;
    end
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CH-1:0] tx_evt_i,
  input  logic [NUM_CH-1:0] rx_evt_i,
  input  logic              host_err_i,
  output logic              irq_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic wr, rd;
  logic set_tx, clr_tx, set_rx, clr_rx, set_dma, clr_dma, eoi_wr;
  logic [NUM_CH-1:0] tx_raw, tx_mask, tx_pend;
  logic [NUM_CH-1:0] rx_raw, rx_mask, rx_pend;
  logic dma_raw, dma_mask, dma_pend;
  logic any_pend;
  logic irq_q;
  logic [31:0] vec;
  logic unused_wdata;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign set_tx  = wr && (addr_i == ADDR_W'(OFS_TX_SET));
  assign clr_tx  = wr && (addr_i == ADDR_W'(OFS_TX_CLR));
  assign set_rx  = wr && (addr_i == ADDR_W'(OFS_RX_SET));
  assign clr_rx  = wr && (addr_i == ADDR_W'(OFS_RX_CLR));
  assign set_dma = wr && (addr_i == ADDR_W'(OFS_DMA_SET));
  assign clr_dma = wr && (addr_i == ADDR_W'(OFS_DMA_CLR));
  assign eoi_wr  = wr && (addr_i == ADDR_W'(OFS_EOI));
  assign unused_wdata = ^wdata_i;

  irq_src_grp #(.W(NUM_CH)) u_tx (
    .clk_i, .rst_ni,
    .src_i(tx_evt_i), .set_i(set_tx), .clr_i(clr_tx),
    .bits_i(wdata_i[NUM_CH-1:0]),
    .raw_o(tx_raw), .mask_o(tx_mask), .pend_o(tx_pend)
  );

  irq_src_grp #(.W(NUM_CH)) u_rx (
    .clk_i, .rst_ni,
    .src_i(rx_evt_i), .set_i(set_rx), .clr_i(clr_rx),
    .bits_i(wdata_i[NUM_CH-1:0]),
    .raw_o(rx_raw), .mask_o(rx_mask), .pend_o(rx_pend)
  );

  irq_src_grp #(.W(1)) u_dma (
    .clk_i, .rst_ni,
    .src_i(host_err_i), .set_i(set_dma), .clr_i(clr_dma),
    .bits_i(wdata_i[HOST_ERR_BIT]),
    .raw_o(dma_raw), .mask_o(dma_mask), .pend_o(dma_pend)
  );

  irq_vec_enc #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_enc (
    .tx_pend_i(tx_pend), .rx_pend_i(rx_pend), .dma_pend_i(dma_pend),
    .vec_o(vec)
  );

  assign any_pend = (|tx_pend) | (|rx_pend) | dma_pend;

  // end-of-interrupt punches a one-cycle hole so a fresh edge follows
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= any_pend & ~eoi_wr;
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        ADDR_W'(OFS_TX_RAW):  rdata_o = 32'(tx_raw);
        ADDR_W'(OFS_TX_MSK):  rdata_o = 32'(tx_pend);
        ADDR_W'(OFS_TX_SET),
        ADDR_W'(OFS_TX_CLR):  rdata_o = 32'(tx_mask);
        ADDR_W'(OFS_RX_RAW):  rdata_o = 32'(rx_raw);
        ADDR_W'(OFS_RX_MSK):  rdata_o = 32'(rx_pend);
        ADDR_W'(OFS_RX_SET),
        ADDR_W'(OFS_RX_CLR):  rdata_o = 32'(rx_mask);
        ADDR_W'(OFS_DMA_RAW): rdata_o[HOST_ERR_BIT] = dma_raw;
        ADDR_W'(OFS_DMA_MSK): rdata_o[HOST_ERR_BIT] = dma_pend;
        ADDR_W'(OFS_DMA_SET),
        ADDR_W'(OFS_DMA_CLR): rdata_o[HOST_ERR_BIT] = dma_mask;
        ADDR_W'(OFS_VECTOR):  rdata_o = vec;
        default:              rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] tx_evt_i,
  input logic [NUM_CH-1:0] tx_raw,
  input logic [NUM_CH-1:0] tx_mask,
  input logic              set_tx,
  input logic              clr_tx,
  input logic [NUM_CH-1:0] wbits,
  input logic              eoi_wr,
  input logic              any_pend,
  input logic              irq_o
);
  // R2
  raw_follows_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tx_raw == $past(tx_evt_i));
  // R3
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_tx && !clr_tx |=> (tx_mask & $past(wbits)) == $past(wbits));
  // R4
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_tx |=> (tx_mask & $past(wbits)) == '0);
  // R8
  irq_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_pend |=> !irq_o);
  // R9
  eoi_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr |=> !irq_o);
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_evt_i(tx_evt_i),
  .tx_raw(tx_raw), .tx_mask(tx_mask), .set_tx(set_tx), .clr_tx(clr_tx),
  .wbits(wdata_i[NUM_CH-1:0]), .eoi_wr(eoi_wr), .any_pend(any_pend),
  .irq_o(irq_o)
);

// File: tb/irq_mask_ctrl_bench.sv
`timescale 1ns/1ps
module irq_mask_ctrl_bench;
  localparam int NCH = 6;
  localparam logic [31:0] CHM = (32'd1 << NCH) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] tx_evt = '0, rx_evt = '0;
  logic host_err = 1'b0, irq;

  int total = 0, bad = 0;
  logic [31:0] m_tx_raw, m_rx_raw, m_dma_raw, m_tx_mask, m_rx_mask, m_dma_mask;
  logic m_irq;

  always #5 clk = ~clk;

  irq_mask_ctrl #(.NUM_CH(NCH), .ADDR_W(8)) u_irq_mask_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
    .host_err_i(host_err), .irq_o(irq)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx_raw <= 0; m_rx_raw <= 0; m_dma_raw <= 0;
      m_tx_mask <= 0; m_rx_mask <= 0; m_dma_mask <= 0; m_irq <= 0;
    end else begin
      m_tx_raw  <= 32'(tx_evt);
      m_rx_raw  <= 32'(rx_evt);
      m_dma_raw <= host_err ? 32'd2 : 32'd0;
      if (req && we) begin
        case (addr)
          8'h88: m_tx_mask  <= m_tx_mask | (wdata & CHM);
          8'h8C: m_tx_mask  <= m_tx_mask & ~wdata;
          8'hA8: m_rx_mask  <= m_rx_mask | (wdata & CHM);
          8'hAC: m_rx_mask  <= m_rx_mask & ~wdata;
          8'hB8: m_dma_mask <= m_dma_mask | (wdata & 32'd2);
          8'hBC: m_dma_mask <= m_dma_mask & ~wdata;
          default: ;
        endcase
      end
      m_irq <= (((m_tx_raw & m_tx_mask) | (m_rx_raw & m_rx_mask) |
                 (m_dma_raw & m_dma_mask)) != 0) && !(req && we && addr == 8'h94);
    end
  end

  function automatic logic [31:0] exp_vec();
    logic [31:0] t = m_tx_raw & m_tx_mask, r = m_rx_raw & m_rx_mask;
    if ((m_dma_raw & m_dma_mask) != 0) return 32'h8000_0201;
    for (int i = 0; i < NCH; i++) if (r[i]) return 32'h8000_0100 | i;
    for (int i = 0; i < NCH; i++) if (t[i]) return 32'h8000_0000 | i;
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h80: return m_tx_raw;
      8'h84: return m_tx_raw & m_tx_mask;
      8'h88, 8'h8C: return m_tx_mask;
      8'hA0: return m_rx_raw;
      8'hA4: return m_rx_raw & m_rx_mask;
      8'hA8, 8'hAC: return m_rx_mask;
      8'hB0: return m_dma_raw;
      8'hB4: return m_dma_raw & m_dma_mask;
      8'hB8, 8'hBC: return m_dma_mask;
      8'h90: return exp_vec();
      default: return 0;
    endcase
  endfunction

  // every-cycle line comparison
  always @(negedge clk) if (rst_n) begin
    total++;
    if (irq !== m_irq) begin
      bad++;
      $display("FAIL R8/R9 irq t=%0t act=%0b exp=%0b", $time, irq, m_irq);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1;
    chk(tag, rdata, exp);
    chk({tag, " model"}, rdata, exp_read(a));
    req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    rd("R1 tx mask", 8'h88, 0);
    rd("R1 rx mask", 8'hA8, 0);
    rd("R1 dma mask", 8'hB8, 0);
    rd("R1 tx raw", 8'h80, 0);
    chk("R1 irq", 32'(irq), 0);
    // R2 raw follows level
    tx_evt = 6'b101001;
    rd("R2 tx raw", 8'h80, 32'h29);
    rx_evt = 6'b010010; host_err = 1;
    rd("R2 rx raw", 8'hA0, 32'h12);
    rd("R2 dma raw", 8'hB0, 32'h2);
    chk("R8 no mask no irq", 32'(irq), 0);
    // R3 set, R5 readback, R6 masked
    wr(8'h88, 32'h9);
    rd("R3 tx set", 8'h88, 32'h9);
    rd("R5 tx via clr", 8'h8C, 32'h9);
    rd("R6 tx masked", 8'h84, 32'h9);
    idle(1);
    chk("R8 irq up", 32'(irq), 1);
    rd("R10 tx ch0", 8'h90, 32'h8000_0000);
    // R10 rx beats tx
    wr(8'hA8, 32'h3C);
    rx_evt = 6'b011000;
    rd("R10 rx ch3", 8'h90, 32'h8000_0103);
    rd("R6 rx masked", 8'hA4, 32'h18);
    // R5 all-ones set limited to channels / bit 1
    wr(8'hB8, 32'hFFFF_FFFF);
    rd("R5 dma mask", 8'hB8, 32'h2);
    rd("R10 dma first", 8'h90, 32'h8000_0201);
    wr(8'h88, 32'hFFFF_FFFF);
    rd("R5 tx mask width", 8'h88, CHM);
    // R9 end of interrupt
    @(negedge clk); req = 1; we = 1; addr = 8'h94; wdata = 0;
    @(negedge clk); req = 0; we = 0;
    chk("R9 irq dropped", 32'(irq), 0);
    @(negedge clk);
    chk("R9 irq rearmed", 32'(irq), 1);
    // R7 writes never touch raw
    wr(8'h80, 32'h0);
    wr(8'h84, 32'h0);
    wr(8'hA0, 32'h0);
    rd("R7 tx raw kept", 8'h80, 32'h29);
    rd("R7 rx raw kept", 8'hA0, 32'h18);
    // R4 clear
    wr(8'hAC, 32'h08);
    rd("R4 rx partial clr", 8'hAC, 32'h34);
    wr(8'hBC, 32'hFFFF_FFFF);
    wr(8'h8C, 32'hFFFF_FFFF);
    wr(8'hAC, 32'hFFFF_FFFF);
    rd("R4 tx cleared", 8'h8C, 0);
    rd("R4 rx cleared", 8'hA8, 0);
    rd("R10 none", 8'h90, 0);
    idle(1);
    chk("R8 irq low after clr", 32'(irq), 0);
    // R11 unmapped
    wr(8'h40, 32'hFFFF_FFFF);
    rd("R11 unmapped", 8'h40, 0);
    rd("R11 unmapped 2", 8'hC0, 0);
    // source drops while masked
    wr(8'hA8, 32'h1);
    rx_evt = 6'b000001;
    idle(2);
    chk("R8 rx irq", 32'(irq), 1);
    rx_evt = 0;
    idle(3);
    chk("R8 source gone", 32'(irq), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule